// File: doc/BRIEF.md
# Pedestal-Subtracted Constant-Fraction Hit Extractor

This block accepts digitized waveform windows of 64 consecutive 12-bit ADC samples from one readout channel. It removes a baseline offset from each sample. The offset comes from a pedestal memory that holds one value per storage cell, and the cell is identified by channel, segment and position in the window. The corrected window is held in a local buffer and scanned once from start to end. Each photon pulse found in the scan becomes a single output record. The record carries a timestamp of sub-sample precision, taken at the point where the leading edge crosses half of the pulse peak, and a charge figure. It is tagged with the channel and segment of the window. The waveform samples themselves never leave the block.

A pulse begins when a corrected sample rises above a programmable threshold. The scan then follows the pulse up to its local maximum. From the peak it walks back to the half-height crossing and interpolates that crossing to 1/16 of a sample. Last, it adds up the corrected samples around the peak. While a window is being scanned the block accepts no new samples. Pedestals are loaded through a separate write port.

Top module: `cfd_hit_extractor`

## Requirements
- R1: After reset, `in_ready` is 1 and `hit_valid` is 0.
- R2: Each accepted sample is corrected to a signed 13-bit value: ADC minus the pedestal stored at address {channel, segment, sample index}, with channel in the top bits and the 6-bit sample index in the bottom bits. Negative results are kept, and a window with only negative excursions yields no hit.
- R3: A pulse starts at the first sample, scanning upward in index, whose corrected value is strictly greater than `thresh` while the detector is armed. The detector is armed at the start of each window. The peak is the first sample at or after that point that is not followed by a strictly larger sample, or the last sample of the window.
- R4: With half = floor(peak/2) and j the highest index below the peak whose value is less than half, `hit_time` = 16*j + floor(16*(half - w[j]) / (w[j+1] - w[j])). A value of exactly 16 is allowed. When no such j exists, `hit_time` is 0.
- R5: `hit_charge` is the signed sum of the corrected samples from peak-4 to peak+8, clipped to indices 0..63.
- R6: After a hit, scanning resumes at peak+1 with the detector disarmed. It re-arms on a sample strictly less than floor(`thresh`/2). Hits from one window are reported in strictly increasing time order.
- R7: `hit_chan` and `hit_seg` equal the channel and segment presented with sample index 0 of the window.
- R8: `in_ready` falls in the cycle after the 64th sample is accepted. It stays low until all hits of the window have been output, and no hit is output while it is high.
- R9: A write on the pedestal port changes the value that later samples of that cell are corrected with.
- R10: Each window produces exactly one `hit_valid` pulse per pulse found under R3 and R6, and nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | 12 | Pulse threshold on corrected samples |
| ped_we | input | 1 | Pedestal write strobe |
| ped_addr | input | 11 | Pedestal cell address {chan, seg, index} |
| ped_wdata | input | 12 | Pedestal value |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_chan | input | 2 | Channel of the sample |
| in_seg | input | 3 | Storage segment of the sample |
| in_adc | input | 12 | Raw ADC sample |
| hit_valid | output | 1 | One-cycle hit record strobe |
| hit_chan | output | 2 | Channel tag of the hit |
| hit_seg | output | 3 | Segment tag of the hit |
| hit_time | output | 10 | Crossing time in 1/16 samples from window start |
| hit_charge | output | 17 | Signed charge sum |

## Verification
Random windows combine per-cell random pedestals, low-level noise, a random threshold and zero to three pulses at random positions and amplitudes. Overlapping pulses in these windows tell correct re-arming apart from double counting, and distinct pedestals per cell tell cell-indexed correction apart from per-channel correction. Directed windows cover the cases random stimulus seldom reaches: a pulse peaking at sample 0, where the crossing search runs out of window; a pulse peaking at the last sample, where charge is clipped; a crossing that lands exactly on a sample, giving a fraction of 16; a second pulse that rises before the signal has dropped far enough to re-arm; and a purely negative window. A pedestal rewrite followed by replay of identical ADC data shows that the write port reaches the subtraction.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    // scanner sequence over one buffered window
    typedef enum logic [2:0] {
        SC_IDLE,
        SC_SEARCH,
        SC_PEAK,
        SC_BACK,
        SC_DIV,
        SC_SUM,
        SC_EMIT,
        SC_FIN
    } scan_st_e;

    localparam int CHARGE_PRE  = 4;
    localparam int CHARGE_POST = 8;

endpackage

// File: rtl/cfd_ped_store.sv
module cfd_ped_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem_q[raddr];
        end
    end

endmodule

// File: rtl/cfd_sub_stage.sv
module cfd_sub_stage #(
    parameter int CHAN_W = 2,
    parameter int SEG_W  = 3,
    parameter int ADC_W  = 12,
    parameter int IDX_W  = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [CHAN_W-1:0]               in_chan,
    input  logic [SEG_W-1:0]                in_seg,
    input  logic [ADC_W-1:0]                in_adc,
    input  logic                            scan_done,
    output logic                            ped_re,
    output logic [CHAN_W+SEG_W+IDX_W-1:0]   ped_raddr,
    input  logic [ADC_W-1:0]                ped_rdata,
    output logic                            wr_en,
    output logic [IDX_W-1:0]                wr_idx,
    output logic signed [ADC_W:0]           wr_val,
    output logic                            wr_last,
    output logic [CHAN_W-1:0]               tag_chan,
    output logic [SEG_W-1:0]                tag_seg
);
    localparam int VAL_W = ADC_W + 1;

    typedef struct packed {
        logic [IDX_W-1:0]  cnt;
        logic              busy;
        logic              vld;
        logic [IDX_W-1:0]  sidx;
        logic [ADC_W-1:0]  adc;
        logic [CHAN_W-1:0] chan;
        logic [SEG_W-1:0]  seg;
    } sub_t;

    sub_t st_d, st_q;
    logic take;

    assign in_ready  = !st_q.busy;
    assign take      = in_valid && !st_q.busy;
    assign ped_re    = take;
    assign ped_raddr = {in_chan, in_seg, st_q.cnt};

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (scan_done) begin
            st_d.busy = 1'b0;
        end
        if (take) begin
            st_d.vld  = 1'b1;
            st_d.sidx = st_q.cnt;
            st_d.adc  = in_adc;
            if (st_q.cnt == '0) begin
                st_d.chan = in_chan;
                st_d.seg  = in_seg;
            end
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt) begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // raw sample minus its cell pedestal, both zero-extended
    assign wr_val   = $signed({1'b0, st_q.adc}) - $signed({1'b0, ped_rdata});
    assign wr_en    = st_q.vld;
    assign wr_idx   = st_q.sidx;
    assign wr_last  = st_q.vld && (&st_q.sidx);
    assign tag_chan = st_q.chan;
    assign tag_seg  = st_q.seg;

    AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !scan_done) |=> !wr_en) else $error("sample entered a busy window"); // R8

    logic unused_val;
    assign unused_val = ^{VAL_W[0]};

endmodule

// File: rtl/cfd_scan.sv
module cfd_scan
    import cfd_pkg::*;
#(
    parameter int ADC_W  = 12,
    parameter int IDX_W  = 6,
    parameter int FRAC_W = 4,
    parameter int PRE    = CHARGE_PRE,
    parameter int POST   = CHARGE_POST
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADC_W-1:0]              thresh,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic signed [ADC_W:0]         wr_val,
    input  logic                          wr_last,
    output logic                          hit_valid,
    output logic [IDX_W+FRAC_W-1:0]       hit_time,
    output logic signed [ADC_W+4:0]       hit_charge,
    output logic                          scan_done
);
    localparam int VAL_W  = ADC_W + 1;
    localparam int NSAMP  = 1 << IDX_W;
    localparam int TIME_W = IDX_W + FRAC_W;
    localparam int SUM_W  = VAL_W + 4;
    localparam int RW     = VAL_W + 3;
    localparam int CNT_W  = $clog2(FRAC_W + 1);
    localparam int KW     = IDX_W + 2;

    typedef struct packed {
        scan_st_e                st;
        logic [IDX_W-1:0]        idx;
        logic                    armed;
        logic [IDX_W-1:0]        pk;
        logic signed [VAL_W-1:0] pv;
        logic signed [IDX_W:0]   jx;
        logic [RW-1:0]           rem;
        logic [RW-1:0]           dvs;
        logic [FRAC_W:0]         quo;
        logic [CNT_W-1:0]        dcnt;
        logic [KW-1:0]           k;
        logic [KW-1:0]           kend;
        logic signed [SUM_W-1:0] acc;
        logic [TIME_W-1:0]       tm;
    } scan_t;

    scan_t sc_d, sc_q;

    logic signed [VAL_W-1:0] wave_q [NSAMP];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            wave_q[wr_idx] <= wr_val;
        end
    end

    logic signed [VAL_W-1:0] thr_s, rearm_s, half_s, v_idx, v_nxt, v_j, v_j1, v_k;
    logic signed [VAL_W+1:0] num_s, den_s;
    logic signed [SUM_W-1:0] v_k_ext;
    logic [RW-1:0]           r_try, r_new;
    logic                    qbit;
    logic [KW-1:0]           k_lo, k_hi;
    logic [IDX_W-1:0]        jl;

    assign thr_s   = $signed({1'b0, thresh});
    assign rearm_s = thr_s >>> 1;
    assign half_s  = sc_q.pv >>> 1;
    assign jl      = sc_q.jx[IDX_W-1:0];
    assign v_idx   = wave_q[sc_q.idx];
    assign v_nxt   = wave_q[sc_q.pk + 1'b1];
    assign v_j     = wave_q[jl];
    assign v_j1    = wave_q[jl + 1'b1];
    assign v_k     = wave_q[sc_q.k[IDX_W-1:0]];
    assign v_k_ext = SUM_W'(v_k);
    assign num_s   = (VAL_W+2)'(half_s) - (VAL_W+2)'(v_j);
    assign den_s   = (VAL_W+2)'(v_j1) - (VAL_W+2)'(v_j);

    // charge window bounds around the peak, clipped at both ends
    assign k_lo = (sc_q.pk >= IDX_W'(PRE)) ? KW'(sc_q.pk - IDX_W'(PRE)) : '0;
    assign k_hi = (KW'(sc_q.pk) + KW'(POST) > KW'(NSAMP - 1)) ? KW'(NSAMP - 1)
                                                               : KW'(sc_q.pk) + KW'(POST);

    // one restoring-division step for the interpolated fraction
    assign r_try = (sc_q.dcnt == '0) ? sc_q.rem : (sc_q.rem << 1);
    assign qbit  = (r_try >= sc_q.dvs);
    assign r_new = qbit ? (r_try - sc_q.dvs) : r_try;

    always_comb begin
        sc_d = sc_q;
        unique case (sc_q.st)
            SC_IDLE: begin
                if (wr_en && wr_last) begin
                    sc_d.st    = SC_SEARCH;
                    sc_d.idx   = '0;
                    sc_d.armed = 1'b1;
                end
            end
            SC_SEARCH: begin
                if (sc_q.armed && (v_idx > thr_s)) begin
                    sc_d.st = SC_PEAK;
                    sc_d.pk = sc_q.idx;
                    sc_d.pv = v_idx;
                end else begin
                    if (v_idx < rearm_s) begin
                        sc_d.armed = 1'b1;
                    end
                    if (&sc_q.idx) begin
                        sc_d.st = SC_FIN;
                    end else begin
                        sc_d.idx = sc_q.idx + 1'b1;
                    end
                end
            end
            SC_PEAK: begin
                if (!(&sc_q.pk) && (v_nxt > sc_q.pv)) begin
                    sc_d.pk = sc_q.pk + 1'b1;
                    sc_d.pv = v_nxt;
                end else begin
                    sc_d.st = SC_BACK;
                    sc_d.jx = $signed({1'b0, sc_q.pk}) - 1;
                end
            end
            SC_BACK: begin
                if (sc_q.jx < 0) begin
                    sc_d.tm   = '0;
                    sc_d.st   = SC_SUM;
                    sc_d.k    = k_lo;
                    sc_d.kend = k_hi;
                    sc_d.acc  = '0;
                end else if (v_j < half_s) begin
                    sc_d.st   = SC_DIV;
                    sc_d.rem  = RW'($unsigned(num_s));
                    sc_d.dvs  = RW'($unsigned(den_s));
                    sc_d.quo  = '0;
                    sc_d.dcnt = '0;
                end else begin
                    sc_d.jx = sc_q.jx - 1;
                end
            end
            SC_DIV: begin
                sc_d.rem  = r_new;
                sc_d.quo  = {sc_q.quo[FRAC_W-1:0], qbit};
                sc_d.dcnt = sc_q.dcnt + 1'b1;
                if (sc_q.dcnt == CNT_W'(FRAC_W)) begin
                    sc_d.tm   = {jl, {FRAC_W{1'b0}}} + TIME_W'({sc_q.quo[FRAC_W-1:0], qbit});
                    sc_d.st   = SC_SUM;
                    sc_d.k    = k_lo;
                    sc_d.kend = k_hi;
                    sc_d.acc  = '0;
                end
            end
            SC_SUM: begin
                sc_d.acc = sc_q.acc + v_k_ext;
                if (sc_q.k == sc_q.kend) begin
                    sc_d.st = SC_EMIT;
                end else begin
                    sc_d.k = sc_q.k + 1'b1;
                end
            end
            SC_EMIT: begin
                if (&sc_q.pk) begin
                    sc_d.st = SC_FIN;
                end else begin
                    sc_d.st    = SC_SEARCH;
                    sc_d.idx   = sc_q.pk + 1'b1;
                    sc_d.armed = 1'b0;
                end
            end
            SC_FIN: begin
                sc_d.st = SC_IDLE;
            end
            default: sc_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign hit_valid  = (sc_q.st == SC_EMIT);
    assign hit_time   = sc_q.tm;
    assign hit_charge = sc_q.acc;
    assign scan_done  = (sc_q.st == SC_FIN);

    AST_PEAK_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (sc_q.pv > thr_s)) else $error("hit peak not above threshold"); // R3

    AST_FRAC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q.st == SC_DIV) |-> (sc_q.rem <= sc_q.dvs)) else $error("interpolation remainder out of range"); // R4

endmodule

// File: rtl/cfd_hit_extractor.sv
module cfd_hit_extractor
    import cfd_pkg::*;
#(
    parameter int CHAN_W = 2,
    parameter int SEG_W  = 3,
    parameter int ADC_W  = 12,
    parameter int IDX_W  = 6,
    parameter int FRAC_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADC_W-1:0]                   thresh,
    input  logic                               ped_we,
    input  logic [CHAN_W+SEG_W+IDX_W-1:0]      ped_addr,
    input  logic [ADC_W-1:0]                   ped_wdata,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [CHAN_W-1:0]                  in_chan,
    input  logic [SEG_W-1:0]                   in_seg,
    input  logic [ADC_W-1:0]                   in_adc,
    output logic                               hit_valid,
    output logic [CHAN_W-1:0]                  hit_chan,
    output logic [SEG_W-1:0]                   hit_seg,
    output logic [IDX_W+FRAC_W-1:0]            hit_time,
    output logic signed [ADC_W+4:0]            hit_charge
);
    localparam int PA_W   = CHAN_W + SEG_W + IDX_W;
    localparam int TIME_W = IDX_W + FRAC_W;
    localparam int NSAMP  = 1 << IDX_W;

    logic                    ped_re;
    logic [PA_W-1:0]         ped_raddr;
    logic [ADC_W-1:0]        ped_rdata;
    logic                    wr_en, wr_last, scan_done;
    logic [IDX_W-1:0]        wr_idx;
    logic signed [ADC_W:0]   wr_val;

    cfd_ped_store #(
        .ADDR_W(PA_W),
        .DATA_W(ADC_W)
    ) u_ped (
        .clk  (clk),
        .we   (ped_we),
        .waddr(ped_addr),
        .wdata(ped_wdata),
        .re   (ped_re),
        .raddr(ped_raddr),
        .rdata(ped_rdata)
    );

    cfd_sub_stage #(
        .CHAN_W(CHAN_W),
        .SEG_W (SEG_W),
        .ADC_W (ADC_W),
        .IDX_W (IDX_W)
    ) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_chan  (in_chan),
        .in_seg   (in_seg),
        .in_adc   (in_adc),
        .scan_done(scan_done),
        .ped_re   (ped_re),
        .ped_raddr(ped_raddr),
        .ped_rdata(ped_rdata),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .wr_last  (wr_last),
        .tag_chan (hit_chan),
        .tag_seg  (hit_seg)
    );

    cfd_scan #(
        .ADC_W (ADC_W),
        .IDX_W (IDX_W),
        .FRAC_W(FRAC_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .thresh    (thresh),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .wr_last   (wr_last),
        .hit_valid (hit_valid),
        .hit_time  (hit_time),
        .hit_charge(hit_charge),
        .scan_done (scan_done)
    );

    // last reported time within the current window, for ordering checks
    logic [TIME_W-1:0] chk_last_q;
    logic              chk_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_last_q <= '0;
            chk_seen_q <= 1'b0;
        end else if (in_ready) begin
            chk_seen_q <= 1'b0;
        end else if (hit_valid) begin
            chk_seen_q <= 1'b1;
            chk_last_q <= hit_time;
        end
    end

    AST_HIT_ONLY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> !in_ready) else $error("hit outside a scanned window"); // R8

    AST_TIME_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_time <= TIME_W'((NSAMP - 1) << FRAC_W))) else $error("hit time beyond last sample"); // R4

    AST_TIME_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && chk_seen_q) |-> (hit_time > chk_last_q)) else $error("hits out of time order"); // R6

endmodule

// File: tb/cfd_hit_extractor_test.sv
module cfd_hit_extractor_test;
    localparam int CHAN_W = 2;
    localparam int SEG_W  = 3;
    localparam int ADC_W  = 12;
    localparam int IDX_W  = 6;
    localparam int FRAC_W = 4;
    localparam int NS     = 64;
    localparam int PA_W   = CHAN_W + SEG_W + IDX_W;
    localparam int NPED   = 1 << PA_W;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [ADC_W-1:0]         thresh = '0;
    logic                     ped_we = 1'b0;
    logic [PA_W-1:0]          ped_addr = '0;
    logic [ADC_W-1:0]         ped_wdata = '0;
    logic                     in_valid = 1'b0;
    logic                     in_ready;
    logic [CHAN_W-1:0]        in_chan = '0;
    logic [SEG_W-1:0]         in_seg = '0;
    logic [ADC_W-1:0]         in_adc = '0;
    logic                     hit_valid;
    logic [CHAN_W-1:0]        hit_chan;
    logic [SEG_W-1:0]         hit_seg;
    logic [IDX_W+FRAC_W-1:0]  hit_time;
    logic signed [ADC_W+4:0]  hit_charge;

    cfd_hit_extractor uut (
        .clk(clk), .rst_n(rst_n), .thresh(thresh),
        .ped_we(ped_we), .ped_addr(ped_addr), .ped_wdata(ped_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
        .in_seg(in_seg), .in_adc(in_adc), .hit_valid(hit_valid),
        .hit_chan(hit_chan), .hit_seg(hit_seg), .hit_time(hit_time),
        .hit_charge(hit_charge)
    );

    always #2 clk = ~clk;

    int ped_m [NPED];
    int wv [NS];
    int adcv [NS];
    int exp_n;
    int exp_t [16];
    int exp_q [16];
    int got_n;
    int got_t [16];
    int got_q [16];
    int got_c [16];
    int got_s [16];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (hit_valid && got_n < 16) begin
            got_t[got_n] = int'(hit_time);
            got_q[got_n] = int'(hit_charge);
            got_c[got_n] = int'(hit_chan);
            got_s[got_n] = int'(hit_seg);
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int shape_pct(input int s);
        case (s)
            0: return 25;
            1: return 75;
            2: return 100;
            3: return 60;
            4: return 35;
            5: return 20;
            6: return 10;
            default: return 5;
        endcase
    endfunction

    // expected hits from corrected samples w and threshold thr
    task automatic build_expect(input int w [NS], input int thr);
        int i, pk, half, j, t, q, armed;
        exp_n = 0;
        i = 0;
        armed = 1;
        while (i < NS) begin
            if (armed != 0 && w[i] > thr) begin
                pk = i;
                while (pk < NS - 1 && w[pk+1] > w[pk]) pk++;
                half = w[pk] / 2;
                j = pk - 1;
                while (j >= 0 && w[j] >= half) j--;
                if (j < 0) t = 0;
                else t = j * 16 + ((half - w[j]) * 16) / (w[j+1] - w[j]);
                q = 0;
                for (int k = pk - 4; k <= pk + 8; k++) begin
                    if (k >= 0 && k < NS) q += w[k];
                end
                if (exp_n < 16) begin
                    exp_t[exp_n] = t;
                    exp_q[exp_n] = q;
                end
                exp_n++;
                armed = 0;
                i = pk + 1;
            end else begin
                if (w[i] < thr / 2) armed = 1;
                i++;
            end
        end
    endtask

    // feed adcv as one window and compare the hits
    task automatic run_adc(input int ch, input int sg, input int thr, input string req);
        int w [NS];
        int lim;
        for (int i = 0; i < NS; i++) w[i] = adcv[i] - ped_m[ch * 512 + sg * 64 + i];
        build_expect(w, thr);
        thresh = ADC_W'(thr);
        got_n = 0;
        while (!in_ready) @(negedge clk);
        for (int i = 0; i < NS; i++) begin
            in_valid = 1'b1;
            in_chan  = CHAN_W'(ch);
            in_seg   = SEG_W'(sg);
            in_adc   = ADC_W'(adcv[i]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R8 ready low after 64th sample", int'(in_ready), 0);
        while (!in_ready) @(negedge clk);
        chk(got_n == exp_n, {"R10 hit count ", req}, got_n, exp_n);
        lim = (got_n < exp_n) ? got_n : exp_n;
        if (lim > 16) lim = 16;
        for (int h = 0; h < lim; h++) begin
            chk(got_t[h] == exp_t[h], {"R4 hit time ", req}, got_t[h], exp_t[h]);
            chk(got_q[h] == exp_q[h], {"R5 charge ", req}, got_q[h], exp_q[h]);
            chk(got_c[h] == ch, "R7 channel tag", got_c[h], ch);
            chk(got_s[h] == sg, "R7 segment tag", got_s[h], sg);
        end
    endtask

    task automatic run_window(input int ch, input int sg, input int thr, input string req);
        for (int i = 0; i < NS; i++) adcv[i] = ped_m[ch * 512 + sg * 64 + i] + wv[i];
        run_adc(ch, sg, thr, req);
    endtask

    task automatic clear_wave();
        for (int i = 0; i < NS; i++) wv[i] = 0;
    endtask

    initial begin
        int seed_init;
        seed_init = int'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        chk(hit_valid == 1'b0, "R1 no hit after reset", int'(hit_valid), 0);

        // R9 load every pedestal cell through the write port
        for (int a = 0; a < NPED; a++) begin
            ped_we    = 1'b1;
            ped_addr  = PA_W'(a);
            ped_m[a]  = 1000 + int'($urandom % 2000);
            ped_wdata = ADC_W'(ped_m[a]);
            @(negedge clk);
        end
        ped_we = 1'b0;

        // R4 R5 pulse peaking at sample 0: crossing search leaves the window
        clear_wave();
        wv[0] = 500; wv[1] = 300; wv[2] = 150; wv[3] = 60; wv[4] = 20;
        run_window(1, 2, 50, "peak at start");

        // R3 R5 pulse still rising at the last sample: charge clipped at end
        clear_wave();
        wv[60] = 100; wv[61] = 250; wv[62] = 400; wv[63] = 700;
        run_window(2, 5, 50, "peak at end");

        // R4 crossing lands exactly on a sample: fraction of 16
        clear_wave();
        wv[20] = 100; wv[21] = 200; wv[22] = 80;
        run_window(0, 0, 60, "exact crossing");

        // R6 second pulse before re-arm is not reported
        clear_wave();
        wv[9] = 300; wv[10] = 600; wv[11] = 200; wv[12] = 100; wv[13] = 300; wv[14] = 500; wv[15] = 40;
        run_window(3, 1, 60, "no rearm");

        // R6 two separated pulses in time order
        clear_wave();
        wv[9] = 300; wv[10] = 600; wv[11] = 200; wv[12] = 0; wv[30] = 150; wv[31] = 450; wv[32] = 90;
        run_window(3, 1, 60, "two pulses");

        // R2 negative excursions only
        for (int i = 0; i < NS; i++) wv[i] = (i % 3 == 0) ? -300 : -5;
        run_window(1, 7, 20, "negative baseline");

        // R2 R9 rewrite three pedestals, replay identical ADC data
        clear_wave();
        wv[20] = 200; wv[21] = 400; wv[22] = 150;
        run_window(2, 3, 100, "before rewrite");
        for (int i = 20; i <= 22; i++) begin
            ped_we    = 1'b1;
            ped_addr  = PA_W'(2 * 512 + 3 * 64 + i);
            ped_m[2 * 512 + 3 * 64 + i] = ped_m[2 * 512 + 3 * 64 + i] + 350;
            ped_wdata = ADC_W'(ped_m[2 * 512 + 3 * 64 + i]);
            @(negedge clk);
        end
        ped_we = 1'b0;
        run_adc(2, 3, 100, "R9 after rewrite");

        // R2 R3 R5 R6 random windows
        for (int n = 0; n < 60; n++) begin
            int thr, np, p, a, ix;
            thr = 40 + int'($urandom % 40);
            for (int i = 0; i < NS; i++) wv[i] = int'($urandom % 21) - 10;
            np = int'($urandom % 4);
            for (int m = 0; m < np; m++) begin
                p = int'($urandom % 64);
                a = 100 + int'($urandom % 900);
                for (int s = 0; s < 8; s++) begin
                    ix = p + s - 2;
                    if (ix >= 0 && ix < NS) wv[ix] += a * shape_pct(s) / 100;
                end
            end
            run_window(int'($urandom % 4), int'($urandom % 8), thr, "random");
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule